// File: doc/BRIEF.md
# Selectable-Network Borrow Subtractor

This block subtracts one unsigned word from another and also takes an incoming borrow. It returns the wrapped difference and an outgoing borrow. It is purely combinational: it has no clock, no reset and no stored state, so a change at the inputs reaches the outputs within the same evaluation.

One elaboration parameter picks the carry network that resolves the borrow chain. The choices are:

- a ripple chain;
- a blocked carry-select chain;
- a Sklansky prefix tree;
- a Brent-Kung prefix tree.

Every choice computes the same function. The choice therefore only trades logic depth against gate count and wiring.

The borrow pins are configured separately. The borrow-in pin can be active-low, active-high or unused. The borrow-out pin has the same three settings. Because the block has no data stream and no storage, it has no valid/ready handshake. Both operands are plain level inputs and both results are plain level outputs.

The difference is formed as A + ~B + c0, where c0 is the inverse of the active-high borrow-in. The active-high borrow-out is the inverse of the final adder carry.

Top module: `prefix_subtractor`

## Requirements
- R1: With borrow-in polarity 1 (active-high), `diff_o` equals the low WIDTH bits of `minuend_i - subtrahend_i - borrow_in_i`.
- R2: With borrow-out polarity 1, `borrow_out_o` is bit WIDTH of the (WIDTH+1)-bit result `{0,minuend_i} - {0,subtrahend_i} - borrow`. This is 1 exactly when minuend < subtrahend + borrow.
- R3: Parameter `BIN_POL` sets the borrow-in polarity:
  - 0: a low pin means borrow 1;
  - 1: a high pin means borrow 1;
  - 2: the pin is ignored and the borrow is taken as 0.
- R4: Parameter `BOUT_POL` sets the borrow-out polarity:
  - 0: the pin carries the inverted borrow;
  - 1: the pin carries the borrow as is;
  - 2: the pin is held at 0.
- R5: Parameter `NET` selects the carry network: 0 ripple, 1 carry-select, 2 Sklansky, 3 Brent-Kung. All four give bit-identical `diff_o` and `borrow_out_o` for every input.
- R6: Any WIDTH of 2 or more is valid, including widths that are not a power of two. R1 to R4 hold at every such width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| minuend_i | input | WIDTH | Operand that is subtracted from |
| subtrahend_i | input | WIDTH | Operand that is subtracted |
| borrow_in_i | input | 1 | Incoming borrow, polarity set by BIN_POL |
| diff_o | output | WIDTH | Wrapped difference |
| borrow_out_o | output | 1 | Outgoing borrow, polarity set by BOUT_POL |

## Verification
A wrong group generate or propagate term in a prefix tree corrupts the carry into some bit position. That error shows up in `diff_o` at that position, and in the borrow-out when it reaches the top. It appears in the same evaluation in which the inputs change, because there is no register in which it could hide. The bench compares every network, polarity pairing and width against a wide-integer model. It also compares each network against the ripple instance of the same configuration. Operands are chosen so that borrows travel the full word and stop at block edges and at non-power-of-two tree tails.

// File: rtl/sub_pkg.sv
package sub_pkg;
  typedef enum int {
    NET_RIPPLE     = 0,
    NET_CSEL       = 1,
    NET_SKLANSKY   = 2,
    NET_BRENT_KUNG = 3
  } net_e;

  localparam int POL_LOW    = 0;
  localparam int POL_HIGH   = 1;
  localparam int POL_UNUSED = 2;
endpackage

// File: rtl/sub_pg.sv
module sub_pg #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);
  logic [WIDTH-1:0] b_n;

  assign b_n    = ~b_i;
  assign gen_o  = a_i & b_n;
  assign prop_o = a_i ^ b_n;
endmodule

// File: rtl/sub_carry_net.sv
module sub_carry_net #(
  parameter int          WIDTH = 8,
  parameter sub_pkg::net_e NET = sub_pkg::NET_SKLANSKY,
  parameter int          BLK   = 4
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  input  logic             c0_i,
  output logic [WIDTH-1:0] cout_o   // carry out of each bit position
);
  localparam int LVL  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int NBLK = (WIDTH + BLK - 1) / BLK;
  localparam int BKS  = 2 * LVL - 1;

  // Bit 0 absorbs the incoming carry, so group terms become true prefixes.
  logic [WIDTH-1:0] g0;
  always_comb begin
    g0    = gen_i;
    g0[0] = gen_i[0] | (prop_i[0] & c0_i);
  end

  generate
    if (NET == sub_pkg::NET_RIPPLE) begin : g_ripple
      always_comb begin
        logic c;
        c = c0_i;
        for (int i = 0; i < WIDTH; i++) begin
          c = gen_i[i] | (prop_i[i] & c);
          cout_o[i] = c;
        end
      end
    end else if (NET == sub_pkg::NET_CSEL) begin : g_csel
      always_comb begin
        logic cb, r0, r1;
        cout_o = '0;
        cb = c0_i;
        for (int k = 0; k < NBLK; k++) begin
          r0 = 1'b0;
          r1 = 1'b1;
          for (int t = 0; t < BLK; t++) begin
            if (k * BLK + t < WIDTH) begin
              r0 = gen_i[k*BLK+t] | (prop_i[k*BLK+t] & r0);
              r1 = gen_i[k*BLK+t] | (prop_i[k*BLK+t] & r1);
              cout_o[k*BLK+t] = cb ? r1 : r0;
            end
          end
          cb = cb ? r1 : r0;
        end
      end
    end else if (NET == sub_pkg::NET_SKLANSKY) begin : g_skl
      for (genvar s = 0; s <= LVL; s++) begin : stg
        logic [WIDTH-1:0] gg, pp;
        if (s == 0) begin : g_base
          assign gg = g0;
          assign pp = prop_i;
        end else begin : g_lvl
          for (genvar i = 0; i < WIDTH; i++) begin : bit_l
            localparam int J = (((i >> (s - 1)) << (s - 1)) - 1);
            if (((i >> (s - 1)) & 1) == 1) begin : g_mix
              assign gg[i] = stg[s-1].gg[i] | (stg[s-1].pp[i] & stg[s-1].gg[J]);
              assign pp[i] = stg[s-1].pp[i] & stg[s-1].pp[J];
            end else begin : g_pass
              assign gg[i] = stg[s-1].gg[i];
              assign pp[i] = stg[s-1].pp[i];
            end
          end
        end
      end
      assign cout_o = stg[LVL].gg;
    end else begin : g_bk
      for (genvar s = 0; s <= BKS; s++) begin : stg
        logic [WIDTH-1:0] gg, pp;
        if (s == 0) begin : g_base
          assign gg = g0;
          assign pp = prop_i;
        end else begin : g_lvl
          localparam bit UP = (s <= LVL);
          localparam int D  = UP ? (1 << (s - 1)) : (1 << (2 * LVL - 1 - s));
          for (genvar i = 0; i < WIDTH; i++) begin : bit_l
            localparam bit MIX = UP ? (((i + 1) % (2 * D)) == 0)
                                    : ((((i + 1) % (2 * D)) == D) && (i >= D));
            if (MIX) begin : g_mix
              assign gg[i] = stg[s-1].gg[i] | (stg[s-1].pp[i] & stg[s-1].gg[i-D]);
              assign pp[i] = stg[s-1].pp[i] & stg[s-1].pp[i-D];
            end else begin : g_pass
              assign gg[i] = stg[s-1].gg[i];
              assign pp[i] = stg[s-1].pp[i];
            end
          end
        end
      end
      assign cout_o = stg[BKS].gg;
    end
  endgenerate

  // R5: whatever the network, each carry must obey the one-bit recurrence
  always_comb begin
    // R5
    net_recur_chk: assert (cout_o[0] == (gen_i[0] | (prop_i[0] & c0_i)));
    for (int i = 1; i < WIDTH; i++) begin
      // R5
      net_chain_chk: assert (cout_o[i] == (gen_i[i] | (prop_i[i] & cout_o[i-1])));
    end
  end
endmodule

// File: rtl/prefix_subtractor.sv
module prefix_subtractor #(
  parameter int            WIDTH    = 8,
  parameter sub_pkg::net_e NET      = sub_pkg::NET_SKLANSKY,
  parameter int            BIN_POL  = 1,
  parameter int            BOUT_POL = 1
) (
  input  logic [WIDTH-1:0] minuend_i,
  input  logic [WIDTH-1:0] subtrahend_i,
  input  logic             borrow_in_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             borrow_out_o
);
  logic             bin_ah;
  logic [WIDTH-1:0] gen, prop, co, cin_vec;
  logic             bor_ah;

  generate
    if (BIN_POL == sub_pkg::POL_LOW) begin : g_bin_low
      assign bin_ah = ~borrow_in_i;
    end else if (BIN_POL == sub_pkg::POL_HIGH) begin : g_bin_high
      assign bin_ah = borrow_in_i;
    end else begin : g_bin_off
      assign bin_ah = 1'b0;
    end
  endgenerate

  sub_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i    (minuend_i),
    .b_i    (subtrahend_i),
    .gen_o  (gen),
    .prop_o (prop)
  );

  sub_carry_net #(.WIDTH(WIDTH), .NET(NET)) u_net (
    .gen_i  (gen),
    .prop_i (prop),
    .c0_i   (~bin_ah),
    .cout_o (co)
  );

  assign cin_vec = {co[WIDTH-2:0], ~bin_ah};
  assign diff_o  = prop ^ cin_vec;
  assign bor_ah  = ~co[WIDTH-1];

  generate
    if (BOUT_POL == sub_pkg::POL_LOW) begin : g_bout_low
      assign borrow_out_o = ~bor_ah;
    end else if (BOUT_POL == sub_pkg::POL_HIGH) begin : g_bout_high
      assign borrow_out_o = bor_ah;
    end else begin : g_bout_off
      assign borrow_out_o = 1'b0;
    end
  endgenerate

  // Arithmetic cross-checks against plain wide operators
  logic [WIDTH:0] ext_ref;
  logic           lt_ref;
  assign ext_ref = {1'b0, minuend_i} - {1'b0, subtrahend_i} - (WIDTH+1)'(bin_ah);
  assign lt_ref  = ({1'b0, minuend_i} < ({1'b0, subtrahend_i} + (WIDTH+1)'(bin_ah)));

  always_comb begin
    // R1
    diff_chk: assert (diff_o == ext_ref[WIDTH-1:0]);
    // R2
    borrow_chk: assert (bor_ah == lt_ref);
    // R4
    bout_pin_chk: assert (borrow_out_o == ((BOUT_POL == 0) ? ~lt_ref :
                                           (BOUT_POL == 1) ?  lt_ref : 1'b0));
  end
endmodule

// File: tb/prefix_subtractor_tb.sv
module prefix_subtractor_tb;
  localparam int NW = 4;
  localparam int NA = 4;
  localparam int NP = 3;
  localparam int N  = NW * NA * NP;

  logic        clk = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        bin = 1'b0;
  int          checks = 0, fails = 0;

  logic [31:0] act_d [N];
  logic [31:0] exp_d [N];
  logic        act_b [N];
  logic        exp_b [N];

  always #5 clk = ~clk;

  for (genvar wi = 0; wi < NW; wi++) begin : g_w
    localparam int W = (wi == 0) ? 2 : (wi == 1) ? 8 : (wi == 2) ? 13 : 32;
    for (genvar ai = 0; ai < NA; ai++) begin : g_a
      for (genvar pi = 0; pi < NP; pi++) begin : g_p
        localparam int IDX = wi * NA * NP + ai * NP + pi;
        localparam int CP  = pi;
        localparam int OP  = (pi + 1) % 3;
        logic [W-1:0] dout;
        logic         bout;
        logic         bin_e;
        logic [W:0]   ext;

        prefix_subtractor #(
          .WIDTH(W), .NET(sub_pkg::net_e'(ai)), .BIN_POL(CP), .BOUT_POL(OP)
        ) u_dut (
          .minuend_i    (a[W-1:0]),
          .subtrahend_i (b[W-1:0]),
          .borrow_in_i  (bin),
          .diff_o       (dout),
          .borrow_out_o (bout)
        );

        assign bin_e = (CP == 0) ? ~bin : (CP == 1) ? bin : 1'b0;
        assign ext   = {1'b0, a[W-1:0]} - {1'b0, b[W-1:0]} - {{W{1'b0}}, bin_e};
        assign act_d[IDX] = 32'(dout);
        assign exp_d[IDX] = 32'(ext[W-1:0]);
        assign act_b[IDX] = bout;
        assign exp_b[IDX] = (OP == 0) ? ~ext[W] : (OP == 1) ? ext[W] : 1'b0;
      end
    end
  end

  function automatic string dtag(int n);
    if (n / (NA * NP) == 2) return "R6";
    if (n % NP != 1) return "R3";
    return "R1";
  endfunction

  function automatic string btag(int n);
    if (((n % NP) + 1) % 3 != 1) return "R4";
    return "R2";
  endfunction

  // Compare every instance on the falling edge, inputs move on the rising edge
  always @(negedge clk) begin
    for (int n = 0; n < N; n++) begin
      checks++;
      if (act_d[n] !== exp_d[n]) begin
        fails++;
        $display("FAIL %s diff inst %0d act %h exp %h", dtag(n), n, act_d[n], exp_d[n]);
      end
      checks++;
      if (act_b[n] !== exp_b[n]) begin
        fails++;
        $display("FAIL %s borrow inst %0d act %b exp %b", btag(n), n, act_b[n], exp_b[n]);
      end
      if ((n / NP) % NA != 0) begin
        int r;
        r = n - ((n / NP) % NA) * NP;
        checks++;
        // R5: every network matches the ripple instance of the same setup
        if (act_d[n] !== act_d[r] || act_b[n] !== act_b[r]) begin
          fails++;
          $display("FAIL R5 inst %0d act %h/%b exp %h/%b", n, act_d[n], act_b[n],
                   act_d[r], act_b[r]);
        end
      end
    end
  end

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic c);
    @(posedge clk);
    a   <= x;
    b   <= y;
    bin <= c;
  endtask

  task automatic run_all();
    logic [31:0] pats [10];
    pats = '{32'h0, 32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h5555_5555,
             32'hAAAA_AAAA, 32'h0000_1000, 32'h0000_0FFF, 32'h7FFF_FFFF, 32'h0000_000F};
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int c = 0; c < 2; c++)
          apply(pats[i], pats[j], c[0]);
    for (int k = 0; k < 3000; k++)
      apply($urandom, $urandom, 1'($urandom));
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog act running exp finished");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule